// File: doc/BRIEF.md
# Dot-Matrix LCD Row/Column Scan Sequencer

This block drives the row and column scanning of a multiplexed dot-matrix character display. For every display row it walks the characters of that row in order and asks, through a lookup port, for each character's 5-dot slice. It then sends those dots one at a time into a 40-stage segment shift register. Once all 40 dots are in place, a single latch cycle copies the shift register into the segment output latch. The same cycle advances a one-hot common (row) select by one position.

The number of scanned rows is chosen at run time: either all 16 commons or only the first 8. A polarity-alternation output flips once per complete frame, so that the analog stage can reverse the drive voltage. Character-pattern storage and the drive voltages are outside the block. The pattern lookup is supplied combinationally by the surrounding logic from the character and row indices that the block presents.

Top module: `lcd_scan_driver`

## Requirements
- R1: While `rst_n` is low, `com_o` and `seg_o` are all zero, `m_o` is 0, and `chr_o` and `row_o` are 0.
- R2: Each row period lasts 41 cycles. In the first 40 cycles `cl2_o` is 1 and `cl1_o` is 0. In the 41st cycle `cl1_o` is 1 and `cl2_o` is 0. The two strobes are never high together.
- R3: In shift cycle k of a row (k = 0..39), `chr_o` equals k/5. `d_o` equals `pat_i[4 - (k mod 5)]`, so the most significant pattern bit goes out first.
- R4: On the latch cycle's clock edge, `seg_o` takes the 40 shifted dots. Bits `seg_o[39-5c -: 5]` hold the pattern of character c (c = 0..7) for that row. `seg_o` does not change in any other cycle.
- R5: After the latch of row r, `com_o` has exactly bit r set. `com_o` changes only on latch edges.
- R6: With `duty16_i` = 1, rows are scanned 0 through 15 and the scan then wraps to row 0.
- R7: With `duty16_i` = 0, rows are scanned 0 through 7 and the scan then wraps. If the row being shifted is at index 8 or above when this mode is selected, that row is still latched, and the scan then wraps to row 0.
- R8: `m_o` inverts on the latch edge of the last row of a frame and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty16_i | input | 1 | 1: scan 16 rows; 0: scan 8 rows |
| pat_i | input | 5 | Dot slice of character `chr_o` on row `row_o` |
| chr_o | output | 4 | Character index being serialized (8 during the latch cycle) |
| row_o | output | 4 | Row index being shifted |
| d_o | output | 1 | Serial dot data entering the segment shift register |
| cl2_o | output | 1 | Shift strobe, high in each dot-shift cycle |
| cl1_o | output | 1 | Latch strobe, high in the row's latch cycle |
| m_o | output | 1 | Frame polarity alternation |
| seg_o | output | 40 | Latched segment columns |
| com_o | output | 16 | One-hot common select |

## Verification
The checker holds several properties on every cycle. It checks that the shift and latch strobes are mutually exclusive and that the common select is at most one-hot and non-empty after a latch. It checks that segments, commons and polarity change only on latch edges, and that the character index stays in range. The bench's scenarios must cover the rest: the actual dot order on `d_o`, the mapping of character patterns into segment bit positions, and which row each latch selects. They must also show the wrap point for each duty setting, including a switch to 8-row mode while a higher row is in flight, and the polarity value after each frame.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;
    localparam int unsigned SEG_COLS  = 40;
    localparam int unsigned DOT_COLS  = 5;
    localparam int unsigned COM_LINES = 16;

    typedef enum logic {
        DUTY_EIGHTH    = 1'b0,
        DUTY_SIXTEENTH = 1'b1
    } duty_e;
endpackage

// File: rtl/lcdscan_timing.sv
module lcdscan_timing
    import lcdscan_pkg::*;
#(
    parameter int unsigned CHARS = SEG_COLS / DOT_COLS,
    parameter int unsigned DOT_N = DOT_COLS,
    parameter int unsigned COM_N = COM_LINES,
    localparam int unsigned CHR_W = $clog2(CHARS + 1),
    localparam int unsigned DOT_W = $clog2(DOT_N),
    localparam int unsigned ROW_W = $clog2(COM_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             duty16_i,
    output logic [CHR_W-1:0] chr_o,
    output logic [DOT_W-1:0] dot_o,
    output logic [ROW_W-1:0] row_o,
    output logic             shift_o,
    output logic             load_o,
    output logic             m_o
);
    localparam logic [CHR_W-1:0] CHR_LOAD = CHR_W'(CHARS);
    localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(DOT_N - 1);
    localparam logic [ROW_W-1:0] ROW_LAST_FULL = ROW_W'(COM_N - 1);
    localparam logic [ROW_W-1:0] ROW_LAST_HALF = ROW_W'(COM_N / 2 - 1);

    typedef struct packed {
        logic [CHR_W-1:0] chr;
        logic [DOT_W-1:0] dot;
        logic [ROW_W-1:0] row;
        logic             m;
    } tstate_t;

    tstate_t s_d, s_q;
    logic             in_load;
    logic             wrap;
    logic [ROW_W-1:0] last_row;

    always_comb begin
        s_d      = s_q;
        in_load  = (s_q.chr == CHR_LOAD);
        last_row = (duty_e'(duty16_i) == DUTY_SIXTEENTH) ? ROW_LAST_FULL : ROW_LAST_HALF;
        wrap     = (s_q.row >= last_row);
        if (in_load) begin
            s_d.chr = '0;
            s_d.dot = '0;
            s_d.row = wrap ? '0 : s_q.row + ROW_W'(1);
            if (wrap) begin
                s_d.m = ~s_q.m;
            end
        end else if (s_q.dot == DOT_LAST) begin
            s_d.dot = '0;
            s_d.chr = s_q.chr + CHR_W'(1);
        end else begin
            s_d.dot = s_q.dot + DOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign chr_o   = s_q.chr;
    assign dot_o   = s_q.dot;
    assign row_o   = s_q.row;
    assign load_o  = in_load;
    assign shift_o = ~in_load;
    assign m_o     = s_q.m;
endmodule

// File: rtl/lcdscan_segpipe.sv
module lcdscan_segpipe
    import lcdscan_pkg::*;
#(
    parameter int unsigned SEG_N = SEG_COLS,
    parameter int unsigned DOT_N = DOT_COLS,
    localparam int unsigned DOT_W = $clog2(DOT_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             load_i,
    input  logic [DOT_W-1:0] dot_i,
    input  logic [DOT_N-1:0] pat_i,
    output logic             d_o,
    output logic [SEG_N-1:0] seg_o
);
    localparam logic [DOT_W-1:0] DOT_TOP = DOT_W'(DOT_N - 1);

    typedef struct packed {
        logic [SEG_N-1:0] sreg;
        logic [SEG_N-1:0] lat;
    } pstate_t;

    pstate_t p_d, p_q;
    logic [DOT_W-1:0] pick;
    logic             dot_bit;

    always_comb begin
        pick    = DOT_TOP - dot_i;
        dot_bit = pat_i[pick];
        p_d     = p_q;
        if (shift_i) begin
            p_d.sreg = {p_q.sreg[SEG_N-2:0], dot_bit};
        end
        if (load_i) begin
            p_d.lat = p_q.sreg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign d_o   = dot_bit;
    assign seg_o = p_q.lat;
endmodule

// File: rtl/lcdscan_comshift.sv
module lcdscan_comshift
    import lcdscan_pkg::*;
#(
    parameter int unsigned COM_N = COM_LINES,
    localparam int unsigned ROW_W = $clog2(COM_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [ROW_W-1:0] row_i,
    output logic [COM_N-1:0] com_o
);
    typedef struct packed {
        logic [COM_N-1:0] token;
    } cstate_t;

    cstate_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (adv_i) begin
            if (row_i == '0) begin
                c_d.token = COM_N'(1);
            end else begin
                c_d.token = c_q.token << 1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign com_o = c_q.token;
endmodule

// File: rtl/lcd_scan_driver.sv
module lcd_scan_driver
    import lcdscan_pkg::*;
#(
    parameter int unsigned SEG_N = SEG_COLS,
    parameter int unsigned DOT_N = DOT_COLS,
    parameter int unsigned COM_N = COM_LINES,
    localparam int unsigned CHARS = SEG_N / DOT_N,
    localparam int unsigned CHR_W = $clog2(CHARS + 1),
    localparam int unsigned DOT_W = $clog2(DOT_N),
    localparam int unsigned ROW_W = $clog2(COM_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             duty16_i,
    input  logic [DOT_N-1:0] pat_i,
    output logic [CHR_W-1:0] chr_o,
    output logic [ROW_W-1:0] row_o,
    output logic             d_o,
    output logic             cl2_o,
    output logic             cl1_o,
    output logic             m_o,
    output logic [SEG_N-1:0] seg_o,
    output logic [COM_N-1:0] com_o
);
    logic [DOT_W-1:0] dot_w;
    logic             shift_w;
    logic             load_w;

    lcdscan_timing #(
        .CHARS (CHARS),
        .DOT_N (DOT_N),
        .COM_N (COM_N)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty16_i (duty16_i),
        .chr_o    (chr_o),
        .dot_o    (dot_w),
        .row_o    (row_o),
        .shift_o  (shift_w),
        .load_o   (load_w),
        .m_o      (m_o)
    );

    lcdscan_segpipe #(
        .SEG_N (SEG_N),
        .DOT_N (DOT_N)
    ) u_segpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_w),
        .load_i  (load_w),
        .dot_i   (dot_w),
        .pat_i   (pat_i),
        .d_o     (d_o),
        .seg_o   (seg_o)
    );

    lcdscan_comshift #(
        .COM_N (COM_N)
    ) u_comshift (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (load_w),
        .row_i (row_o),
        .com_o (com_o)
    );

    assign cl2_o = shift_w;
    assign cl1_o = load_w;
endmodule

// File: rtl/lcd_scan_driver_chk.sv
module lcd_scan_driver_chk #(
    parameter int unsigned SEG_N = 40,
    parameter int unsigned COM_N = 16,
    parameter int unsigned CHR_W = 4,
    parameter int unsigned CHARS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CHR_W-1:0] chr_o,
    input logic             cl1_o,
    input logic             cl2_o,
    input logic             m_o,
    input logic [SEG_N-1:0] seg_o,
    input logic [COM_N-1:0] com_o
);
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cl1_o && cl2_o) && (cl1_o || cl2_o));

    assert_chr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chr_o <= CHR_W'(CHARS));

    assert_seg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cl1_o |=> $stable(seg_o));

    assert_com_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(com_o));

    assert_com_after_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cl1_o |=> $countones(com_o) == 1);

    assert_com_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cl1_o |=> $stable(com_o));

    assert_m_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cl1_o |=> $stable(m_o));
endmodule

bind lcd_scan_driver lcd_scan_driver_chk #(
    .SEG_N (SEG_N),
    .COM_N (COM_N),
    .CHR_W (CHR_W),
    .CHARS (CHARS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .chr_o (chr_o),
    .cl1_o (cl1_o),
    .cl2_o (cl2_o),
    .m_o   (m_o),
    .seg_o (seg_o),
    .com_o (com_o)
);

// File: tb/tb_lcd_scan_driver.sv
`timescale 1ns/1ps
module tb_lcd_scan_driver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        duty16 = 1'b1;
    logic [4:0]  pat;
    logic [3:0]  chr;
    logic [3:0]  row;
    logic        d;
    logic        cl2;
    logic        cl1;
    logic        m;
    logic [39:0] seg;
    logic [15:0] com;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    lcd_scan_driver dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty16_i (duty16),
        .pat_i    (pat),
        .chr_o    (chr),
        .row_o    (row),
        .d_o      (d),
        .cl2_o    (cl2),
        .cl1_o    (cl1),
        .m_o      (m),
        .seg_o    (seg),
        .com_o    (com)
    );

    function automatic logic [4:0] patf(int c, int r);
        return 5'((c * 7 + r * 11 + 3) ^ (r << 2));
    endfunction

    function automatic logic [39:0] expseg(int r);
        logic [39:0] s = '0;
        for (int c = 0; c < 8; c++) s[39-5*c -: 5] = patf(c, r);
        return s;
    endfunction

    assign pat = patf(int'(chr), int'(row));

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {duty16, latches to wait, expected last latched row, expected m}
    localparam logic [10:0] VEC [10] = '{
        {1'b1, 5'd5,  4'd5,  1'b0},
        {1'b1, 5'd10, 4'd15, 1'b1},   // R6 full frame ends, polarity flips
        {1'b1, 5'd1,  4'd0,  1'b1},   // R6 wrap
        {1'b0, 5'd7,  4'd7,  1'b0},   // R7 short frame
        {1'b0, 5'd1,  4'd0,  1'b0},
        {1'b0, 5'd8,  4'd0,  1'b1},
        {1'b1, 5'd9,  4'd9,  1'b1},
        {1'b0, 5'd1,  4'd10, 1'b0},   // R7 row above 8 in flight when switched
        {1'b0, 5'd1,  4'd0,  1'b0},
        {1'b0, 5'd3,  4'd3,  1'b0}
    };

    task automatic wait_latches(int n);
        repeat (n) begin
            while (!cl1) @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check_reset();
        check("R1 com", 64'(com), 64'h0);
        check("R1 seg", 64'(seg), 64'h0);
        check("R1 m", 64'(m), 64'h0);
        check("R1 chr", 64'(chr), 64'h0);
        check("R1 row", 64'(row), 64'h0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        // First row, cycle by cycle: strobes, fetch order, serial dots
        for (int k = 0; k < 41; k++) begin
            if (k < 40) begin
                check("R2 cl2 high", 64'(cl2), 64'h1);
                check("R2 cl1 low", 64'(cl1), 64'h0);
                check("R3 chr index", 64'(chr), 64'(k / 5));
                check("R3 serial dot", 64'(d), 64'(patf(k / 5, 0) >> (4 - k % 5)) & 64'h1);
            end else begin
                check("R2 cl1 high", 64'(cl1), 64'h1);
                check("R2 cl2 low", 64'(cl2), 64'h0);
            end
            @(negedge clk);
        end
        check("R4 seg row0", 64'(seg), 64'(expseg(0)));
        check("R5 com row0", 64'(com), 64'h1);
        check("R8 m after row0", 64'(m), 64'h0);

        for (int v = 0; v < 10; v++) begin
            duty16 = VEC[v][10];
            wait_latches(int'(VEC[v][9:5]));
            check("R5 com select", 64'(com), 64'(16'(1) << VEC[v][4:1]));
            check("R4 seg content", 64'(seg), 64'(expseg(int'(VEC[v][4:1]))));
            check("R8 m polarity", 64'(m), 64'(VEC[v][0]));
            repeat (20) @(negedge clk);
            check("R4 seg held", 64'(seg), 64'(expseg(int'(VEC[v][4:1]))));
            check("R5 com held", 64'(com), 64'(16'(1) << VEC[v][4:1]));
            check("R8 m held", 64'(m), 64'(VEC[v][0]));
        end

        // Reset in mid-scan
        rst_n = 1'b0;
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        duty16 = 1'b1;
        wait_latches(2);
        check("R5 com row1 after reset", 64'(com), 64'h2);
        check("R4 seg row1 after reset", 64'(seg), 64'(expseg(1)));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule